// File: doc/BRIEF.md
# Multi-Writer Shared Control Register Bank

This block holds a small bank of equal-width control registers that many client ports reach at once. Every port presents a register index, a write flag, write data packed into its low bits, a right-aligned valid-bits mask that gives the write width, and a bit offset that moves the masked data up into the wanted field. There is no arbitration between ports. Each cycle, every legal write aimed at a register is combined bitwise and stored. A build-time polarity parameter picks OR or AND as the combining operator.

Each port always reads back the whole stored word of the register it selects. A port can therefore own one field of a register and watch another. The stored word is rebuilt from the current contributions on every clock. A register that nobody drives falls back to the identity value of the merge: zero for OR, all ones for AND. A request whose field would run past the top bit, or whose index names no register, is dropped, and the port is told so by a registered error flag.

Top module: `shreg_bank`

## Requirements
- R1: With POLARITY = MERGE_OR, the value a register stores after a clock edge is the bitwise OR of the shifted fields of every legal write aimed at it in that cycle. Any number of ports may take part.
- R2: With POLARITY = MERGE_AND, the stored value is the bitwise AND of the contributions. Each contribution carries the writer's data inside its shifted field and ones everywhere else.
- R3: A write takes data bits where port_mask is 1, with bit 0 of the mask matching bit 0 of the data. It moves them left by port_off. Register bits outside mask<<offset get the merge identity from that writer.
- R4: A write is illegal if its index is NUM_REGS or above, or if its mask is non-zero and (highest set mask bit + port_off) is REG_W or above. An illegal write contributes nothing. The port's port_err is 1 in the cycle after the request and 0 after any other request.
- R5: A port with port_wr = 0 contributes nothing, whatever its data, mask and offset. It never raises port_err, and it still receives the selected register.
- R6: A write is not visible on port_rdata before the clock edge that stores it. It is visible right after that edge, one cycle later.
- R7: A register that no legal write targets in a cycle takes the identity value at the next edge: 0 in OR mode, all ones in AND mode. Reset also loads this value.
- R8: port_rdata of each port is the full stored word of the register its port_idx selects. An index of NUM_REGS or above reads as the identity value.
- R9: Ports that present different indices update different registers independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_idx | input | NUM_PORTS*IDX_W | Register index per port; port p uses slice p |
| port_wr | input | NUM_PORTS | 1 = port writes this cycle; 0 = read only |
| port_data | input | NUM_PORTS*REG_W | Right-aligned write data per port |
| port_mask | input | NUM_PORTS*REG_W | Right-aligned valid-bits mask per port |
| port_off | input | NUM_PORTS*OFF_W | Left shift applied to the masked data |
| port_rdata | output | NUM_PORTS*REG_W | Stored word of the selected register per port |
| port_err | output | NUM_PORTS | Registered flag for a dropped illegal write |

## Verification
The read path is combinational from the stored bank, so a change of index is due at once. A write and its error flag are due only after the next rising edge. The bench drives inputs just after a falling edge. One nanosecond later it compares every read port against the model's old bank, which proves that a write has not leaked through before its edge. At the following falling edge, with the same inputs still held, it compares the read data and the error flags against the model's updated bank and flags. One OR-mode and one AND-mode instance run side by side on the same stimulus, so both merge polarities are checked every cycle.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
    typedef enum logic {
        MERGE_OR  = 1'b0,
        MERGE_AND = 1'b1
    } merge_pol_e;
endpackage

// File: rtl/shreg_lane.sv
module shreg_lane
    import shreg_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int NUM_REGS = 6,
    parameter int IDX_W    = 3,
    parameter int OFF_W    = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    input  logic [REG_W-1:0] data,
    input  logic [REG_W-1:0] mask,
    input  logic [OFF_W-1:0] off,
    output logic             wr_ok,
    output logic             wr_bad,
    output logic [REG_W-1:0] field_mask,
    output logic [REG_W-1:0] field_data
);
    localparam logic [IDX_W:0] NREG_L = NUM_REGS[IDX_W:0];

    int  top_bit;
    logic bad_idx;
    logic bad_rng;

    always_comb begin
        top_bit = -1;
        for (int b = 0; b < REG_W; b++) begin
            if (mask[b]) top_bit = b;
        end
        bad_idx    = ({1'b0, idx} >= NREG_L);
        bad_rng    = (top_bit >= 0) && ((top_bit + int'(off)) >= REG_W);
        wr_bad     = wr && (bad_idx || bad_rng);
        wr_ok      = wr && !bad_idx && !bad_rng;
        field_mask = mask << off;
        field_data = (data & mask) << off;
    end

    // R5: a read-only lane never produces a write
    always_comb begin
        if (!wr) assert_ro_silent_R5: assert (!wr_ok && !wr_bad);
    end
endmodule

// File: rtl/shreg_merge.sv
module shreg_merge
    import shreg_pkg::*;
#(
    parameter int         NUM_PORTS = 4,
    parameter int         REG_W     = 16,
    parameter int         IDX_W     = 3,
    parameter int         REG_ID    = 0,
    parameter merge_pol_e POLARITY  = MERGE_OR
) (
    input  logic [NUM_PORTS-1:0]            ok,
    input  logic [NUM_PORTS-1:0][IDX_W-1:0] idx,
    input  logic [NUM_PORTS-1:0][REG_W-1:0] fmask,
    input  logic [NUM_PORTS-1:0][REG_W-1:0] fdata,
    output logic [REG_W-1:0]                nxt,
    output logic                            hit
);
    localparam logic [IDX_W-1:0] MY_ID = IDX_W'(REG_ID);
    localparam logic [REG_W-1:0] IDENT = (POLARITY == MERGE_AND) ? '1 : '0;

    always_comb begin
        nxt = IDENT;
        hit = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (ok[p] && (idx[p] == MY_ID)) begin
                hit = 1'b1;
                if (POLARITY == MERGE_AND) nxt = nxt & (fdata[p] | ~fmask[p]);
                else                       nxt = nxt | fdata[p];
            end
        end
    end
endmodule

// File: rtl/shreg_bank.sv
module shreg_bank
    import shreg_pkg::*;
#(
    parameter int         NUM_PORTS = 4,
    parameter int         NUM_REGS  = 6,
    parameter int         REG_W     = 16,
    parameter merge_pol_e POLARITY  = MERGE_OR,
    parameter int         IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    parameter int         OFF_W     = (REG_W > 1) ? $clog2(REG_W) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_PORTS*IDX_W-1:0]   port_idx,
    input  logic [NUM_PORTS-1:0]         port_wr,
    input  logic [NUM_PORTS*REG_W-1:0]   port_data,
    input  logic [NUM_PORTS*REG_W-1:0]   port_mask,
    input  logic [NUM_PORTS*OFF_W-1:0]   port_off,
    output logic [NUM_PORTS*REG_W-1:0]   port_rdata,
    output logic [NUM_PORTS-1:0]         port_err
);
    localparam logic [REG_W-1:0] IDENT  = (POLARITY == MERGE_AND) ? '1 : '0;
    localparam logic [IDX_W:0]   NREG_L = NUM_REGS[IDX_W:0];

    logic [NUM_PORTS-1:0]            lane_ok;
    logic [NUM_PORTS-1:0]            lane_bad;
    logic [NUM_PORTS-1:0][IDX_W-1:0] lane_idx;
    logic [NUM_PORTS-1:0][REG_W-1:0] lane_fm;
    logic [NUM_PORTS-1:0][REG_W-1:0] lane_fd;
    logic [NUM_REGS-1:0][REG_W-1:0]  bank_d;
    logic [NUM_REGS-1:0][REG_W-1:0]  bank_q;
    logic [NUM_REGS-1:0]             reg_hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        assign lane_idx[p] = port_idx[p*IDX_W +: IDX_W];
        shreg_lane #(
            .REG_W(REG_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .OFF_W(OFF_W)
        ) lane_i (
            .idx        (lane_idx[p]),
            .wr         (port_wr[p]),
            .data       (port_data[p*REG_W +: REG_W]),
            .mask       (port_mask[p*REG_W +: REG_W]),
            .off        (port_off[p*OFF_W +: OFF_W]),
            .wr_ok      (lane_ok[p]),
            .wr_bad     (lane_bad[p]),
            .field_mask (lane_fm[p]),
            .field_data (lane_fd[p])
        );

        // R8: out-of-range index reads identity, otherwise the stored word
        always_comb begin
            if ({1'b0, lane_idx[p]} < NREG_L)
                port_rdata[p*REG_W +: REG_W] = bank_q[lane_idx[p]];
            else
                port_rdata[p*REG_W +: REG_W] = IDENT;
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        shreg_merge #(
            .NUM_PORTS(NUM_PORTS), .REG_W(REG_W), .IDX_W(IDX_W),
            .REG_ID(r), .POLARITY(POLARITY)
        ) merge_i (
            .ok    (lane_ok),
            .idx   (lane_idx),
            .fmask (lane_fm),
            .fdata (lane_fd),
            .nxt   (bank_d[r]),
            .hit   (reg_hit[r])
        );

        assert_idle_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !reg_hit[r] |=> (bank_q[r] == IDENT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q   <= {NUM_REGS{IDENT}};
            port_err <= '0;
        end else begin
            bank_q   <= bank_d;
            port_err <= lane_bad;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_err_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            port_err[p] |-> $past(port_wr[p]));

        assert_top_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (port_wr[p] && port_mask[p*REG_W + REG_W-1] && (port_off[p*OFF_W +: OFF_W] != '0))
            |=> port_err[p]);

        if (POLARITY == MERGE_OR) begin : g_or
            assert_or_keeps_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
                lane_ok[p] |=> ((bank_q[$past(lane_idx[p])] & $past(lane_fd[p])) == $past(lane_fd[p])));
        end else begin : g_and
            assert_and_keeps_zeros_R2: assert property (@(posedge clk) disable iff (!rst_n)
                lane_ok[p] |=> ((bank_q[$past(lane_idx[p])] & $past(lane_fm[p]) & ~$past(lane_fd[p])) == '0));
        end
    end
endmodule

// File: tb/shreg_bank_tb.sv
module shreg_bank_tb_top;
    import shreg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NR = 6;
    localparam int RW = 16;
    localparam int IW = 3;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP*IW-1:0] port_idx  = '0;
    logic [NP-1:0]    port_wr   = '0;
    logic [NP*RW-1:0] port_data = '0;
    logic [NP*RW-1:0] port_mask = '0;
    logic [NP*OW-1:0] port_off  = '0;
    logic [NP*RW-1:0] rd_or, rd_and;
    logic [NP-1:0]    err_or, err_and;

    always #(CLK_PERIOD/2) clk = ~clk;

    shreg_bank #(.NUM_PORTS(NP), .NUM_REGS(NR), .REG_W(RW), .POLARITY(MERGE_OR)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_idx(port_idx), .port_wr(port_wr),
        .port_data(port_data), .port_mask(port_mask), .port_off(port_off),
        .port_rdata(rd_or), .port_err(err_or));

    shreg_bank #(.NUM_PORTS(NP), .NUM_REGS(NR), .REG_W(RW), .POLARITY(MERGE_AND)) dut_and_i (
        .clk(clk), .rst_n(rst_n), .port_idx(port_idx), .port_wr(port_wr),
        .port_data(port_data), .port_mask(port_mask), .port_off(port_off),
        .port_rdata(rd_and), .port_err(err_and));

    // stimulus slots and reference model
    int          t_idx[NP];
    bit          t_wr[NP];
    logic [15:0] t_data[NP];
    int          t_width[NP];
    int          t_off[NP];
    logic [15:0] m_or[NR];
    logic [15:0] m_and[NR];
    logic [15:0] n_or[NR];
    logic [15:0] n_and[NR];
    bit          n_err[NP];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    task automatic chk(string req, string what, int p, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s port%0d: got %h expected %h", req, what, p, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_model(bit and_mode, int idx);
        if (idx >= NR) return and_mode ? 16'hFFFF : 16'h0000;
        return and_mode ? m_and[idx] : m_or[idx];
    endfunction

    task automatic idle_all();
        for (int p = 0; p < NP; p++) begin
            t_idx[p] = p; t_wr[p] = 0; t_data[p] = '0; t_width[p] = 0; t_off[p] = 0;
        end
    endtask

    task automatic apply(string tag);
        logic [15:0] msk;
        for (int r = 0; r < NR; r++) begin
            n_or[r] = 16'h0000; n_and[r] = 16'hFFFF;
        end
        for (int p = 0; p < NP; p++) begin
            msk = '0;
            for (int b = 0; b < t_width[p]; b++) msk[b] = 1'b1;
            port_idx[p*IW +: IW]  = IW'(t_idx[p]);
            port_wr[p]            = t_wr[p];
            port_data[p*RW +: RW] = t_data[p];
            port_mask[p*RW +: RW] = msk;
            port_off[p*OW +: OW]  = OW'(t_off[p]);
            n_err[p] = t_wr[p] && (t_idx[p] >= NR || (t_width[p] > 0 && t_width[p] - 1 + t_off[p] >= RW));
            if (t_wr[p] && !n_err[p]) begin
                for (int b = 0; b < t_width[p]; b++) begin
                    if (t_data[p][b]) n_or[t_idx[p]][b + t_off[p]] = 1'b1;
                    else              n_and[t_idx[p]][b + t_off[p]] = 1'b0;
                end
            end
        end
        #1;
        for (int p = 0; p < NP; p++) begin
            chk("R6", "pre-edge OR rdata", p, rd_or[p*RW +: RW], rd_model(0, t_idx[p]));
            chk("R6", "pre-edge AND rdata", p, rd_and[p*RW +: RW], rd_model(1, t_idx[p]));
        end
        @(negedge clk);
        for (int r = 0; r < NR; r++) begin
            m_or[r] = n_or[r]; m_and[r] = n_and[r];
        end
        for (int p = 0; p < NP; p++) begin
            chk(tag, "OR rdata", p, rd_or[p*RW +: RW], rd_model(0, t_idx[p]));
            chk(tag, "AND rdata", p, rd_and[p*RW +: RW], rd_model(1, t_idx[p]));
            chk(tag, "OR err", p, 16'(err_or[p]), 16'(n_err[p]));
            chk(tag, "AND err", p, 16'(err_and[p]), 16'(n_err[p]));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int r = 0; r < NR; r++) begin m_or[r] = 16'h0000; m_and[r] = 16'hFFFF; end
        idle_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset value is the identity of each merge
        idle_all();
        apply("R7");

        // R1 / R2 / R3: two ports hit register 2 with overlapping shifted fields
        idle_all();
        t_idx[0] = 2; t_wr[0] = 1; t_data[0] = 16'h00A5; t_width[0] = 8; t_off[0] = 0;
        t_idx[1] = 2; t_wr[1] = 1; t_data[1] = 16'h000C; t_width[1] = 4; t_off[1] = 6;
        t_idx[2] = 2; t_idx[3] = 2;
        apply("R1");

        // R3: masked-off data bits must not leak; high field at offset 12
        idle_all();
        t_idx[0] = 3; t_wr[0] = 1; t_data[0] = 16'hFFF3; t_width[0] = 4; t_off[0] = 12;
        t_idx[1] = 3; t_wr[1] = 1; t_data[1] = 16'hFF00; t_width[1] = 2; t_off[1] = 0;
        t_idx[2] = 3;
        apply("R3");

        // R2: three writers of register 0 in AND mode, each with zeros in its field
        idle_all();
        for (int p = 0; p < 3; p++) begin
            t_idx[p] = 0; t_wr[p] = 1; t_data[p] = 16'h0005; t_width[p] = 4; t_off[p] = 4 * p;
        end
        t_idx[3] = 0;
        apply("R2");

        // R4: offset overflow, index past the bank, and an exact top-bit fit
        idle_all();
        t_idx[0] = 1; t_wr[0] = 1; t_data[0] = 16'h00FF; t_width[0] = 8; t_off[0] = 9;
        t_idx[1] = 6; t_wr[1] = 1; t_data[1] = 16'h0001; t_width[1] = 1;
        t_idx[2] = 1; t_wr[2] = 1; t_data[2] = 16'h00FF; t_width[2] = 8; t_off[2] = 8;
        t_idx[3] = 7; t_wr[3] = 1; t_data[3] = 16'h0000; t_width[3] = 0;
        apply("R4");

        // R5: read-only ports carry junk that must have no effect
        idle_all();
        for (int p = 0; p < NP; p++) begin
            t_idx[p] = 1; t_wr[p] = 0; t_data[p] = 16'h5A5A; t_width[p] = 16; t_off[p] = 3;
        end
        apply("R5");

        // R9: four ports write four different registers
        idle_all();
        for (int p = 0; p < NP; p++) begin
            t_idx[p] = p + 2; t_wr[p] = 1; t_data[p] = 16'(16'h1111 * (p + 1)); t_width[p] = 16;
        end
        apply("R9");

        // R8: out-of-range reads and full-word readback of held values
        idle_all();
        t_idx[0] = 6; t_idx[1] = 7; t_idx[2] = 4; t_idx[3] = 5;
        apply("R8");

        // R7: nobody writes, everything settles to identity
        idle_all();
        apply("R7");
        apply("R7");

        // R3: mixed traffic
        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < NP; p++) begin
                t_idx[p]   = $urandom_range(0, 7);
                t_wr[p]    = ($urandom_range(0, 3) != 0);
                t_data[p]  = 16'($urandom);
                t_width[p] = $urandom_range(0, 16);
                t_off[p]   = $urandom_range(0, 15);
            end
            apply("R3");
        end

        finish_run();
    end
endmodule